// File: doc/BRIEF.md
# Translated Write-Through Data Cache Access Path

This block serves one load or store at a time. It first maps the virtual page number of the request through a small fully associative translation buffer. It then checks the write permission of the matched page. Last, it looks up a direct-mapped data store that is tagged with the physical address. Page entries are installed one at a time by external refill logic through a load port, and a flush input drops every entry at once.

A read that hits returns its word in the same cycle. A read that misses stalls the requester while the block fetches the word from memory through a request/acknowledge port, and the retried lookup then hits. A permitted write updates the line and pushes the physical address and data into an external write buffer in the same cycle. This makes main memory write-through. When the buffer reports full, the write waits.

An access that finds no page mapping raises a miss exception. A store to a page without write permission raises a protection exception and changes nothing. The requester holds a request until it sees either the done pulse or an exception flag.

Top module: `xlat_dcache`

## Requirements
- R1: The physical address is the 20-bit physical page number of the matching entry above the untranslated low 12 bits of the virtual address. The virtual page number is `req_vaddr[31:12]`, and `wb_addr` carries the full physical address.
- R2: `tlb_load_en` writes one entry at `tlb_load_idx` with a page number, a frame number and a write-permission bit, and marks it valid. `tlb_flush` invalidates every entry, so later accesses to those pages miss.
- R3: While a request finds no valid matching entry, `exc_tlb_miss` is 1, and `done`, `stall` and `wb_push` are 0.
- R4: A write to a matched page whose permission bit is 0 raises `exc_wprot`. It causes no push and leaves the data store unchanged.
- R5: A permitted write with `wb_full` low completes in the cycle it is presented. It asserts `done` and `wb_push` with `wb_data` equal to the write data, and a later read of that word returns the written data.
- R6: A read that hits completes in the cycle it is presented, with `rd_data` equal to the stored word. `rd_data` is 0 whenever no read completes.
- R7: A read that misses asserts `stall`. From the next cycle, `mem_req` is held with `mem_addr` = the physical address with bits 1:0 cleared until `mem_ack`. The line is then filled with `mem_rdata`, and the following cycle completes the read.
- R8: With `done`, `page_dirty` gives the page's dirty bit including the current access: 1 on any write, and for a read the bit as stored. Loading an entry clears its dirty bit.
- R9: While `wb_full` is 1, a permitted write holds `stall` high and does not push. It completes in the first cycle in which `wb_full` is 0.
- R10: A line is selected by physical address bits `[IDX_W+1:2]` and tagged by the bits above them. A fill or write for another address with the same index replaces the line, and the byte offset does not take part in the lookup.
- R11: At most one exception flag is high. A write that finds no mapping reports only the miss.
- R12: After reset the outputs are idle and both the translation entries and the lines are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until done or an exception |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| rd_data | output | 32 | Load data, valid with done |
| done | output | 1 | Access completes this cycle |
| stall | output | 1 | Access is waiting (fill or full write buffer) |
| exc_tlb_miss | output | 1 | No mapping for the page |
| exc_wprot | output | 1 | Store to a page without write permission |
| page_dirty | output | 1 | Dirty bit of the accessed page, valid with done |
| tlb_load_en | input | 1 | Install an entry |
| tlb_load_idx | input | TLB_IW | Slot to install |
| tlb_load_vpn | input | 20 | Virtual page number of the new entry |
| tlb_load_ppn | input | 20 | Physical frame number of the new entry |
| tlb_load_wok | input | 1 | Write permission of the new entry |
| tlb_flush | input | 1 | Invalidate all entries |
| mem_req | output | 1 | Line fill request |
| mem_addr | output | 32 | Word-aligned fill address |
| mem_ack | input | 1 | Fill data valid |
| mem_rdata | input | 32 | Fill data |
| wb_push | output | 1 | Push into the write buffer |
| wb_addr | output | 32 | Physical address pushed |
| wb_data | output | 32 | Data pushed |
| wb_full | input | 1 | Write buffer cannot accept |

## Verification
The bench builds the block with 16 translation slots and `IDX_W` = 6, which gives 64 lines. Two pages then collide on the same line whenever their page offsets agree in bits 7:2. This brings eviction, refill after a refused store and byte-offset aliasing within reach with a handful of addresses. The last slot (index 15) and the all-ones page are used to cover the top of both the slot range and the address space. A fill latency of three cycles keeps the acknowledge well apart from the request edge.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned PN_W   = ADDR_W - OFF_W;

  typedef enum logic {SEQ_LOOK, SEQ_FILL} seq_t;

  // line number of a physical byte address for a store of 2**iw words
  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] pa,
                                                input int unsigned iw);
    return (pa >> 2) & ((32'd1 << iw) - 32'd1);
  endfunction

  // bits of a physical byte address above the line number
  function automatic logic [ADDR_W-1:0] tag_of(input logic [ADDR_W-1:0] pa,
                                               input int unsigned iw);
    return pa >> (iw + 2);
  endfunction
endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PPN_W = 20,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             load_en,
  input  logic [IW-1:0]    load_idx,
  input  logic [VPN_W-1:0] load_vpn,
  input  logic [PPN_W-1:0] load_ppn,
  input  logic             load_wok,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic             set_dirty,
  output logic             hit,
  output logic [PPN_W-1:0] ppn,
  output logic             wok,
  output logic             dirty
);
  logic [DEPTH-1:0] vld, drt, perm;
  logic [VPN_W-1:0] vtag [DEPTH];
  logic [PPN_W-1:0] pnum [DEPTH];
  logic [DEPTH-1:0] match;
  logic [IW-1:0]    hit_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld[g] && (vtag[g] == look_vpn);
  end

  // lowest matching slot wins
  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end

  assign hit   = |match;
  assign ppn   = pnum[hit_idx];
  assign wok   = perm[hit_idx];
  assign dirty = drt[hit_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      drt <= '0;
    end else begin
      if (flush) vld <= '0;
      if (set_dirty) drt[hit_idx] <= 1'b1;
      if (load_en) begin
        vld[load_idx] <= 1'b1;
        drt[load_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      vtag[load_idx] <= load_vpn;
      pnum[load_idx] <= load_ppn;
      perm[load_idx] <= load_wok;
    end
  end
endmodule

// File: rtl/xlat_line_store.sv
module xlat_line_store #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TAG_W  = 22,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  look_idx,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              hit,
  output logic [DATA_W-1:0] rdata,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [LINES-1:0]  lvld;
  logic [TAG_W-1:0]  ltag [LINES];
  logic [DATA_W-1:0] ldat [LINES];

  assign hit   = lvld[look_idx] && (ltag[look_idx] == look_tag);
  assign rdata = ldat[look_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvld <= '0;
    else if (wr_en) lvld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ltag[wr_idx] <= wr_tag;
      ldat[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/xlat_seq.sv
module xlat_seq
  import xlat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic tlb_hit,
  input  logic tlb_wok,
  input  logic line_hit,
  input  logic wb_full,
  input  logic mem_ack,
  output logic done,
  output logic stall,
  output logic exc_miss,
  output logic exc_wprot,
  output logic push,
  output logic store_req,
  output logic store_fill,
  output logic mark_dirty,
  output logic mem_req,
  output logic start_fill
);
  seq_t st, nxt;

  always_comb begin
    nxt        = st;
    done       = 1'b0;
    stall      = 1'b0;
    exc_miss   = 1'b0;
    exc_wprot  = 1'b0;
    push       = 1'b0;
    store_req  = 1'b0;
    store_fill = 1'b0;
    mark_dirty = 1'b0;
    mem_req    = 1'b0;
    start_fill = 1'b0;
    case (st)
      SEQ_LOOK: begin
        if (req_valid) begin
          if (!tlb_hit) begin
            exc_miss = 1'b1;
          end else if (req_write) begin
            if (!tlb_wok) begin
              exc_wprot = 1'b1;
            end else if (wb_full) begin
              stall = 1'b1;
            end else begin
              done       = 1'b1;
              push       = 1'b1;
              store_req  = 1'b1;
              mark_dirty = 1'b1;
            end
          end else if (line_hit) begin
            done = 1'b1;
          end else begin
            stall      = 1'b1;
            start_fill = 1'b1;
            nxt        = SEQ_FILL;
          end
        end
      end
      SEQ_FILL: begin
        stall   = 1'b1;
        mem_req = 1'b1;
        if (mem_ack) begin
          store_fill = 1'b1;
          nxt        = SEQ_LOOK;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SEQ_LOOK;
    else        st <= nxt;
  end
endmodule

// File: rtl/xlat_dcache.sv
module xlat_dcache
  import xlat_pkg::*;
#(
  parameter int unsigned TLB_DEPTH = 16,
  parameter int unsigned IDX_W     = 8,
  localparam int unsigned TLB_IW = $clog2(TLB_DEPTH),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_vaddr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              done,
  output logic              stall,
  output logic              exc_tlb_miss,
  output logic              exc_wprot,
  output logic              page_dirty,
  input  logic              tlb_load_en,
  input  logic [TLB_IW-1:0] tlb_load_idx,
  input  logic [19:0]       tlb_load_vpn,
  input  logic [19:0]       tlb_load_ppn,
  input  logic              tlb_load_wok,
  input  logic              tlb_flush,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              wb_push,
  output logic [31:0]       wb_addr,
  output logic [31:0]       wb_data,
  input  logic              wb_full
);
  // named internal events
  logic              tlb_hit, tlb_wok, tlb_dirty;
  logic [PN_W-1:0]   tlb_ppn;
  logic              line_hit;
  logic [31:0]       line_rdata;
  logic              store_req, store_fill, mark_dirty, start_fill;
  logic [ADDR_W-1:0] pa, fill_pa;
  logic [ADDR_W-3:0] fill_word_q;
  logic [IDX_W-1:0]  look_idx, wr_idx;
  logic [TAG_W-1:0]  look_tag, wr_tag;

  xlat_tlb #(.DEPTH(TLB_DEPTH), .VPN_W(PN_W), .PPN_W(PN_W)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(tlb_flush),
    .load_en(tlb_load_en), .load_idx(tlb_load_idx), .load_vpn(tlb_load_vpn),
    .load_ppn(tlb_load_ppn), .load_wok(tlb_load_wok),
    .look_vpn(req_vaddr[ADDR_W-1:OFF_W]), .set_dirty(mark_dirty),
    .hit(tlb_hit), .ppn(tlb_ppn), .wok(tlb_wok), .dirty(tlb_dirty)
  );

  assign pa       = {tlb_ppn, req_vaddr[OFF_W-1:0]};
  assign fill_pa  = {fill_word_q, 2'b00};
  assign look_idx = IDX_W'(line_of(pa, IDX_W));
  assign look_tag = TAG_W'(tag_of(pa, IDX_W));
  assign wr_idx   = store_fill ? IDX_W'(line_of(fill_pa, IDX_W)) : look_idx;
  assign wr_tag   = store_fill ? TAG_W'(tag_of(fill_pa, IDX_W))  : look_tag;

  xlat_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(32)) u_lines (
    .clk(clk), .rst_n(rst_n), .look_idx(look_idx), .look_tag(look_tag),
    .hit(line_hit), .rdata(line_rdata),
    .wr_en(store_req | store_fill), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_data(store_fill ? mem_rdata : req_wdata)
  );

  xlat_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .tlb_hit(tlb_hit), .tlb_wok(tlb_wok), .line_hit(line_hit),
    .wb_full(wb_full), .mem_ack(mem_ack),
    .done(done), .stall(stall), .exc_miss(exc_tlb_miss), .exc_wprot(exc_wprot),
    .push(wb_push), .store_req(store_req), .store_fill(store_fill),
    .mark_dirty(mark_dirty), .mem_req(mem_req), .start_fill(start_fill)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fill_word_q <= '0;
    else if (start_fill) fill_word_q <= pa[ADDR_W-1:2];
  end

  assign rd_data    = (done && !req_write) ? line_rdata : '0;
  assign page_dirty = done & (tlb_dirty | mark_dirty);
  assign mem_addr   = fill_pa;
  assign wb_addr    = pa;
  assign wb_data    = req_wdata;
endmodule

// File: rtl/xlat_dcache_chk.sv
module xlat_dcache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        wb_full,
  input logic        done,
  input logic        stall,
  input logic        exc_tlb_miss,
  input logic        exc_wprot,
  input logic        wb_push,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        page_dirty,
  input logic        tlb_hit
);
  a_r3_miss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    exc_tlb_miss |-> !done && !wb_push && !stall);
  a_r4_wprot_silent: assert property (@(posedge clk) disable iff (!rst_n)
    exc_wprot |-> !wb_push && !done);
  a_r5_push_is_store: assert property (@(posedge clk) disable iff (!rst_n)
    wb_push |-> done && req_write && req_valid);
  a_r7_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr));
  a_r7_fill_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> stall && !done);
  a_r8_store_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req_write) |-> page_dirty);
  a_r9_full_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    wb_full |-> !wb_push);
  a_r11_miss_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tlb_hit && !mem_req) |-> exc_tlb_miss && !exc_wprot);
  a_r11_one_exc: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({exc_tlb_miss, exc_wprot}) <= 1);
endmodule

bind xlat_dcache xlat_dcache_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .wb_full(wb_full), .done(done), .stall(stall), .exc_tlb_miss(exc_tlb_miss),
  .exc_wprot(exc_wprot), .wb_push(wb_push), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .page_dirty(page_dirty), .tlb_hit(tlb_hit)
);

// File: tb/sim_xlat_dcache.sv
`timescale 1ns/100ps
module sim_xlat_dcache;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned IDXW  = 6;
  localparam int unsigned LINES = 1 << IDXW;
  localparam logic [31:0] MEMX  = 32'hC3A5_5A3C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_vaddr = '0, req_wdata = '0;
  logic tlb_load_en = 0, tlb_load_wok = 0, tlb_flush = 0;
  logic [3:0] tlb_load_idx = '0;
  logic [19:0] tlb_load_vpn = '0, tlb_load_ppn = '0;
  logic mem_ack = 0, wb_full = 0;
  logic [31:0] mem_rdata;
  logic [31:0] rd_data, mem_addr, wb_addr, wb_data;
  logic done, stall, exc_tlb_miss, exc_wprot, page_dirty, mem_req, wb_push;

  xlat_dcache #(.TLB_DEPTH(DEPTH), .IDX_W(IDXW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
    .stall(stall), .exc_tlb_miss(exc_tlb_miss), .exc_wprot(exc_wprot),
    .page_dirty(page_dirty), .tlb_load_en(tlb_load_en), .tlb_load_idx(tlb_load_idx),
    .tlb_load_vpn(tlb_load_vpn), .tlb_load_ppn(tlb_load_ppn), .tlb_load_wok(tlb_load_wok),
    .tlb_flush(tlb_flush), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .wb_push(wb_push), .wb_addr(wb_addr), .wb_data(wb_data),
    .wb_full(wb_full)
  );

  always #2.5 clk = ~clk;
  assign mem_rdata = mem_addr ^ MEMX;

  int n_cmp = 0, n_bad = 0;
  bit reported = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit          mv [DEPTH];
  bit          mw [DEPTH];
  bit          md [DEPTH];
  logic [19:0] mvpn [DEPTH];
  logic [19:0] mppn [DEPTH];
  bit          cv [LINES];
  logic [31:0] ct [LINES];
  logic [31:0] cd [LINES];
  bit          m_fill;
  logic [31:0] m_faddr;
  bit          d_wr, d_go, d_end;
  int          d_hit, d_li;
  logic [31:0] d_lt, d_pa, d_wd;

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_done, e_stall, e_miss, e_wp, e_push, e_mreq, e_dirty;
      logic [31:0] e_rd, pa, lt;
      int h, li;
      e_done = 0; e_stall = 0; e_miss = 0; e_wp = 0; e_push = 0; e_mreq = 0;
      e_dirty = 0; e_rd = 0; pa = 0; lt = 0; li = 0; h = -1;
      d_wr = 0; d_go = 0; d_end = 0;
      if (m_fill) begin
        e_stall = 1; e_mreq = 1; d_end = mem_ack;
      end else if (req_valid) begin
        for (int i = 0; i < DEPTH; i++)
          if (h < 0 && mv[i] && mvpn[i] == req_vaddr[31:12]) h = i;
        if (h < 0) e_miss = 1;
        else begin
          pa = {mppn[h], req_vaddr[11:0]};
          li = int'((pa / 4) % LINES);
          lt = pa / (4 * LINES);
          if (req_write && !mw[h]) e_wp = 1;
          else if (req_write) begin
            if (wb_full) e_stall = 1;
            else begin
              e_done = 1; e_push = 1; e_dirty = 1;
              d_wr = 1; d_hit = h; d_li = li; d_lt = lt; d_wd = req_wdata;
            end
          end else if (cv[li] && ct[li] == lt) begin
            e_done = 1; e_rd = cd[li]; e_dirty = md[h];
          end else begin
            e_stall = 1; d_go = 1; d_pa = pa;
          end
        end
      end
      chk("R6 done", done, e_done);
      chk("R7 stall", stall, e_stall);
      chk("R3 exc_tlb_miss", exc_tlb_miss, e_miss);
      chk("R4 exc_wprot", exc_wprot, e_wp);
      chk("R5 wb_push", wb_push, e_push);
      chk("R7 mem_req", mem_req, e_mreq);
      chk("R6 rd_data", rd_data, e_rd);
      if (e_push) begin
        chk("R1 wb_addr", wb_addr, pa);
        chk("R5 wb_data", wb_data, req_wdata);
      end
      if (e_done) chk("R8 page_dirty", page_dirty, e_dirty);
      if (e_mreq) chk("R7 mem_addr", mem_addr, m_faddr);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; md[i] = 0; end
      for (int i = 0; i < LINES; i++) cv[i] = 0;
      m_fill = 0; m_faddr = 0; d_wr = 0; d_go = 0; d_end = 0;
    end else begin
      if (d_wr) begin
        md[d_hit] = 1; cv[d_li] = 1; ct[d_li] = d_lt; cd[d_li] = d_wd;
      end
      if (d_end) begin
        int fl;
        fl = int'((m_faddr / 4) % LINES);
        cv[fl] = 1; ct[fl] = m_faddr / (4 * LINES); cd[fl] = m_faddr ^ MEMX;
        m_fill = 0;
      end
      if (d_go) begin m_fill = 1; m_faddr = {d_pa[31:2], 2'b00}; end
      if (tlb_flush) for (int i = 0; i < DEPTH; i++) mv[i] = 0;
      if (tlb_load_en) begin
        mv[tlb_load_idx] = 1; md[tlb_load_idx] = 0; mw[tlb_load_idx] = tlb_load_wok;
        mvpn[tlb_load_idx] = tlb_load_vpn; mppn[tlb_load_idx] = tlb_load_ppn;
      end
      d_wr = 0; d_go = 0; d_end = 0;
    end
  end

  // ---------------- memory responder: ack three cycles into a fill ----------------
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(posedge clk); #1;
      if (mem_ack) begin mem_ack = 0; cnt = 0; end
      else if (mem_req) begin
        cnt++;
        if (cnt == 3) mem_ack = 1;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic w, input logic [31:0] va, input logic [31:0] wd);
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_vaddr = va; req_wdata = wd;
    @(negedge clk);
  endtask

  task automatic retire();
    while (!(done || exc_tlb_miss || exc_wprot)) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic tlb_put(input int idx, input logic [19:0] vpn, input logic [19:0] ppn,
                         input logic wok);
    @(posedge clk); #1;
    tlb_load_en = 1; tlb_load_idx = 4'(idx); tlb_load_vpn = vpn;
    tlb_load_ppn = ppn; tlb_load_wok = wok;
    @(posedge clk); #1;
    tlb_load_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R12 done idle", done, 0);
    chk("R12 stall idle", stall, 0);
    chk("R12 mem_req idle", mem_req, 0);
    chk("R12 wb_push idle", wb_push, 0);
    issue(0, 32'h1234_5010, 0);
    chk("R12 no mapping after reset", exc_tlb_miss, 1);
    retire();

    tlb_put(0, 20'h12345, 20'h00ABC, 1);
    tlb_put(1, 20'h00001, 20'h00002, 0);
    tlb_put(15, 20'hFFFFF, 20'h7FFFF, 1);

    issue(0, 32'h1234_5010, 0);
    chk("R7 read miss stalls", stall, 1);
    chk("R7 read miss not done", done, 0);
    retire();

    issue(0, 32'h1234_5010, 0);
    chk("R6 hit completes at once", done, 1);
    chk("R6 hit data", rd_data, 32'h00AB_C010 ^ MEMX);
    chk("R8 fresh page clean", page_dirty, 0);
    retire();

    issue(1, 32'h1234_5012, 32'hDEAD_BEEF);
    chk("R5 store pushes", wb_push, 1);
    chk("R1 translated push address", wb_addr, 32'h00AB_C012);
    chk("R8 store marks dirty", page_dirty, 1);
    retire();

    issue(0, 32'h1234_5010, 0);
    chk("R5 stored word read back", rd_data, 32'hDEAD_BEEF);
    chk("R8 dirty kept on read", page_dirty, 1);
    retire();

    issue(1, 32'h0000_1010, 32'h1111_2222);
    chk("R4 protected store refused", exc_wprot, 1);
    chk("R4 refused store no push", wb_push, 0);
    retire();

    issue(0, 32'h0000_1010, 0);
    chk("R4 refused store left line untouched", stall, 1);
    retire();

    issue(0, 32'h1234_5010, 0);
    chk("R10 evicted line misses", stall, 1);
    retire();

    issue(0, 32'h1234_5013, 0);
    chk("R10 byte offset ignored by lookup", done, 1);
    retire();

    issue(1, 32'h5555_5000, 32'h1);
    chk("R11 miss reported", exc_tlb_miss, 1);
    chk("R11 protection not reported", exc_wprot, 0);
    retire();

    wb_full = 1;
    issue(1, 32'hFFFF_FFFC, 32'hA5A5_0001);
    chk("R9 stall while buffer full", stall, 1);
    chk("R9 no push while buffer full", wb_push, 0);
    @(negedge clk);
    chk("R9 still waiting", stall, 1);
    @(posedge clk); #1 wb_full = 0;
    @(negedge clk);
    chk("R9 push once buffer frees", wb_push, 1);
    chk("R1 top slot and top page", wb_addr, 32'h7FFF_FFFC);
    retire();

    @(posedge clk); #1 tlb_flush = 1;
    @(posedge clk); #1 tlb_flush = 0;
    issue(0, 32'h1234_5010, 0);
    chk("R2 flushed mapping misses", exc_tlb_miss, 1);
    retire();

    tlb_put(3, 20'h12345, 20'h00ABC, 1);
    issue(0, 32'h1234_5010, 0);
    chk("R2 reloaded mapping hits", done, 1);
    chk("R8 load clears dirty", page_dirty, 0);
    retire();

    for (int k = 0; k < 24; k++) begin
      logic [31:0] va;
      va = (k % 2 == 1) ? {20'h12345, 12'(k * 36)} : {20'hFFFFF, 12'(k * 52)};
      issue(k % 3 == 0, va, 32'(k) * 32'h0101_0101);
      retire();
    end

    repeat (4) @(posedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    report();
  end
endmodule